// File: doc/BRIEF.md
# Command-Addressed Serial Register Port

This block is the serial slave port of a converter-style register file. The host first shifts in one command byte. That byte names a register and a direction. The next transfer moves exactly as many bits as that register holds, which is 8, 16 or 24. The port then returns to waiting for a command. There is no address phase outside the command byte. Because of this, the link works with only clock, data in and data out, with chip select held low permanently.

A read command can also start a streaming mode. In that mode the addressed register is reloaded and shifted out burst after burst. The host does not send a new command between bursts. The port keeps listening on the data input during every burst, and a fixed exit byte ends the stream. A polarity input selects whether the serial clock idles low or high. A ready flag records that a new result is waiting in the data register. It appears both on an active-low pin and in bit 7 of the status register.

Serial inputs are synchronised into the system clock domain, and edges are found by oversampling. The serial clock half period must be at least four system clock cycles. The register file is outside the block. It is reached through an address, a write strobe with write data, and a combinational read-data return.

Top module: `cmdSerialSlave`

## Requirements
- R1: A command byte is bit 6 = read (1) or write (0), bit 5 = streaming read, and bits 2:0 = register address. The byte 0xFF is a no-op: it causes no access and the port keeps waiting for a command.
- R2: Register lengths are fixed by address: 0 → 8 bits, 2 → 16 bits, 4 → 8 bits, and every other address → 24 bits. Each data phase is exactly that long, and then the port expects a command again.
- R3: A write issues exactly one `rfWrEn` pulse, one clock wide, within 4 system clocks of the last data bit. It carries the command's address and the data, zero-extended.
- R4: A data phase may follow the 8 command bits with no break, for example command plus 8-bit data in one 16-bit burst.
- R5: A 32-bit write to a 24-bit register whose last 8 bits are all ones writes the first 24 bits once and leaves the port waiting for a command.
- R6: Read data leaves MSB first. Each bit is shifted on the drive edge so that it is valid at the next sample edge. `doutOe` is high only during a read data phase. At all other times `doutOut` is 0, including during writes (half duplex).
- R7: In streaming read (command bit 5 = 1 with bit 6 = 1), the register is sent again in every burst. If the last 8 DIN bits of a burst equal 0x30, the port leaves streaming when that burst ends. Any other DIN content is ignored.
- R8: With `polSel` = 0, SCLK idles low, the rising edge drives DOUT and the falling edge samples DIN. With `polSel` = 1 both edges are swapped.
- R9: Holding `csN` high aborts any transfer, clears the bit count and the streaming mode, and forces `doutOe` low within 4 clocks. With `csN` held low the port runs on command framing alone.
- R10: A `newResult` pulse asserts `resultReadyN` low on the next clock and sets status bit 7. A completed read of the data register (address 1) clears the flag. A new result arriving in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select, may be tied low |
| dinIn | input | 1 | Serial data from the host |
| polSel | input | 1 | SCLK idle level: 0 idles low, 1 idles high |
| newResult | input | 1 | One-cycle pulse when a new data-register result exists |
| rfRdData | input | 24 | Read data of the register at `rfAddr` |
| doutOut | output | 1 | Serial data to the host |
| doutOe | output | 1 | Output enable for `doutOut` |
| resultReadyN | output | 1 | Low while an unread result is pending |
| rfAddr | output | 3 | Register address from the last command |
| rfWrData | output | 24 | Write data, zero-extended to 24 bits |
| rfWrEn | output | 1 | One-cycle write strobe |

## Verification
The port has no framing apart from the bit count, so a wrong count or a wrong phase state has a lasting effect. Every later byte is then split in the wrong place. A following readback returns shifted data, and a later write lands at the wrong address or never fires. The directed tests therefore always follow each access with a second one, which shows such drift within one byte. A stuck streaming flag shows as `doutOe` staying high during the next command. A bad ready flag shows on `resultReadyN` one clock after its cause.

// File: rtl/cmdslv_pkg.sv
package cmdslv_pkg;
  localparam int DW = 24;
  localparam int AW = 3;
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;

  typedef struct packed {
    logic          load;
    logic          shiftIn;
    logic          shiftOut;
    logic          capture;
    logic          rdyClr;
    logic          outOn;
    logic [CW-1:0] len;
    logic [AW-1:0] addr;
  } dpCtl_t;

  function automatic logic [CW-1:0] regLen(input logic [AW-1:0] a);
    case (a)
      3'd0:    regLen = CW'(8);
      3'd2:    regLen = CW'(16);
      3'd4:    regLen = CW'(8);
      default: regLen = CW'(24);
    endcase
  endfunction
endpackage

// File: rtl/cmdslvCtrl.sv
module cmdslvCtrl
  import cmdslv_pkg::*;
#(
  parameter logic [AW-1:0] DATA_ADDR = 3'd1,
  parameter logic [7:0]    EXIT_CODE = 8'h30,
  parameter logic [7:0]    NOP_CODE  = 8'hFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclkIn,
  input  logic          csN,
  input  logic          dinIn,
  input  logic          polSel,
  input  logic [7:0]    inLow,
  output logic          dinS,
  output dpCtl_t        ctl,
  output logic [AW-1:0] rfAddr,
  output logic          rfWrEn
);
  logic [2:0]    sclkQ;
  logic [1:0]    dinQ;
  logic [1:0]    csQ;
  logic          csS;
  logic          driveEv;
  logic          sampleEv;
  phase_e        phase;
  logic [CW-1:0] bitCnt;
  logic [CW-1:0] len;
  logic          lastBit;
  logic [AW-1:0] addrQ;
  logic          contQ;
  logic          loadPend;
  logic          wrEnQ;

  // normalise the clock so that its idle level is always 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= '0;
      dinQ  <= '0;
      csQ   <= 2'b11;
    end else begin
      sclkQ <= {sclkQ[1:0], sclkIn ^ polSel};
      dinQ  <= {dinQ[0], dinIn};
      csQ   <= {csQ[0], csN};
    end
  end

  always_comb begin
    csS      = csQ[1];
    dinS     = dinQ[1];
    driveEv  = sclkQ[1] & ~sclkQ[2] & ~csS;
    sampleEv = ~sclkQ[1] & sclkQ[2] & ~csS;
    len      = (phase == PH_CMD) ? CW'(8) : regLen(addrQ);
    lastBit  = (bitCnt == len - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_CMD;
      bitCnt   <= '0;
      addrQ    <= '0;
      contQ    <= 1'b0;
      loadPend <= 1'b0;
      wrEnQ    <= 1'b0;
    end else begin
      loadPend <= 1'b0;
      wrEnQ    <= 1'b0;
      if (csS) begin
        phase  <= PH_CMD;
        bitCnt <= '0;
        contQ  <= 1'b0;
      end else if (sampleEv) begin
        if (!lastBit) begin
          bitCnt <= bitCnt + 1'b1;
        end else begin
          bitCnt <= '0;
          case (phase)
            PH_CMD: begin
              if (inLow != NOP_CODE) begin
                addrQ <= inLow[AW-1:0];
                if (inLow[6]) begin
                  phase    <= PH_RD;
                  contQ    <= inLow[5];
                  loadPend <= 1'b1;
                end else begin
                  phase <= PH_WR;
                end
              end
            end
            PH_WR: begin
              wrEnQ <= 1'b1;
              phase <= PH_CMD;
            end
            default: begin
              if (contQ && inLow != EXIT_CODE) begin
                loadPend <= 1'b1;
              end else begin
                contQ <= 1'b0;
                phase <= PH_CMD;
              end
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    ctl.load     = loadPend;
    ctl.shiftIn  = sampleEv;
    ctl.shiftOut = driveEv & (phase == PH_RD);
    ctl.capture  = sampleEv & lastBit & (phase == PH_WR);
    ctl.rdyClr   = sampleEv & lastBit & (phase == PH_RD) & (addrQ == DATA_ADDR);
    ctl.outOn    = (phase == PH_RD);
    ctl.len      = regLen(addrQ);
    ctl.addr     = addrQ;
    rfAddr       = addrQ;
    rfWrEn       = wrEnQ;
  end
endmodule

// File: rtl/cmdslvData.sv
module cmdslvData
  import cmdslv_pkg::*;
#(
  parameter logic [AW-1:0] STATUS_ADDR = 3'd0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dinS,
  input  dpCtl_t        ctl,
  input  logic [DW-1:0] rfRdData,
  input  logic          newResult,
  output logic [7:0]    inLow,
  output logic [DW-1:0] rfWrData,
  output logic          doutOut,
  output logic          doutOe,
  output logic          resultReadyN
);
  logic [DW-1:0] inShift;
  logic [DW-1:0] inNext;
  logic [DW-1:0] outShift;
  logic [DW-1:0] rdVal;
  logic [DW-1:0] lenMask;
  logic          outBit;
  logic          readyQ;
  logic [DW-1:0] wrDataQ;

  always_comb begin
    inNext  = {inShift[DW-2:0], dinS};
    inLow   = inNext[7:0];
    lenMask = ~({DW{1'b1}} << ctl.len);
    rdVal   = rfRdData;
    if (ctl.addr == STATUS_ADDR) rdVal[7] = readyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift  <= '0;
      outShift <= '0;
      outBit   <= 1'b0;
      readyQ   <= 1'b0;
      wrDataQ  <= '0;
    end else begin
      if (ctl.shiftIn) inShift <= inNext;
      if (ctl.capture) wrDataQ <= inNext & lenMask;
      if (ctl.load) begin
        outShift <= rdVal << (DW - int'(ctl.len));
        outBit   <= 1'b0;
      end else if (ctl.shiftOut) begin
        outBit   <= outShift[DW-1];
        outShift <= outShift << 1;
      end
      if (newResult)       readyQ <= 1'b1;
      else if (ctl.rdyClr) readyQ <= 1'b0;
    end
  end

  always_comb begin
    rfWrData     = wrDataQ;
    doutOe       = ctl.outOn;
    doutOut      = ctl.outOn & outBit;
    resultReadyN = ~readyQ;
  end
endmodule

// File: rtl/cmdSerialSlave.sv
module cmdSerialSlave
  import cmdslv_pkg::*;
#(
  parameter logic [AW-1:0] STATUS_ADDR = 3'd0,
  parameter logic [AW-1:0] DATA_ADDR   = 3'd1,
  parameter logic [7:0]    EXIT_CODE   = 8'h30,
  parameter logic [7:0]    NOP_CODE    = 8'hFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclkIn,
  input  logic          csN,
  input  logic          dinIn,
  input  logic          polSel,
  input  logic          newResult,
  input  logic [DW-1:0] rfRdData,
  output logic          doutOut,
  output logic          doutOe,
  output logic          resultReadyN,
  output logic [AW-1:0] rfAddr,
  output logic [DW-1:0] rfWrData,
  output logic          rfWrEn
);
  dpCtl_t     ctl;
  logic       dinS;
  logic [7:0] inLow;

  cmdslvCtrl #(
    .DATA_ADDR(DATA_ADDR),
    .EXIT_CODE(EXIT_CODE),
    .NOP_CODE (NOP_CODE)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclkIn(sclkIn),
    .csN   (csN),
    .dinIn (dinIn),
    .polSel(polSel),
    .inLow (inLow),
    .dinS  (dinS),
    .ctl   (ctl),
    .rfAddr(rfAddr),
    .rfWrEn(rfWrEn)
  );

  cmdslvData #(
    .STATUS_ADDR(STATUS_ADDR)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .dinS        (dinS),
    .ctl         (ctl),
    .rfRdData    (rfRdData),
    .newResult   (newResult),
    .inLow       (inLow),
    .rfWrData    (rfWrData),
    .doutOut     (doutOut),
    .doutOe      (doutOe),
    .resultReadyN(resultReadyN)
  );
endmodule

// File: rtl/cmdSerialSlave_chk.sv
module cmdSerialSlave_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic newResult,
  input logic resultReadyN,
  input logic rfWrEn,
  input logic doutOe,
  input logic doutOut
);
  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |=> !rfWrEn);

  p_wr_not_reading_r6: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> !doutOe);

  p_quiet_dout_r6: assert property (@(posedge clk) disable iff (!rstN)
    !doutOe |-> !doutOut);

  p_ready_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    newResult |=> !resultReadyN);

  p_cs_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN, 1) && $past(csN, 2) && $past(csN, 3)) |-> (!doutOe && !rfWrEn));
endmodule

bind cmdSerialSlave cmdSerialSlave_chk uChk (.*);

// File: tb/cmdSerialSlave_test.sv
`timescale 1ns/1ps
module cmdSerialSlave_test;
  localparam int HALF = 80;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b0;
  logic        csN = 1'b0;
  logic        dinIn = 1'b1;
  logic        polSel = 1'b0;
  logic        newResult = 1'b0;
  logic [23:0] rfRdData;
  logic        doutOut;
  logic        doutOe;
  logic        resultReadyN;
  logic [2:0]  rfAddr;
  logic [23:0] rfWrData;
  logic        rfWrEn;

  logic [23:0] mem [8];
  int          wrCount = 0;
  int          total = 0;
  int          bad = 0;
  logic [31:0] capQ;
  bit          oeSeen;

  always #5 clk = ~clk;

  cmdSerialSlave uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csN(csN), .dinIn(dinIn),
    .polSel(polSel), .newResult(newResult), .rfRdData(rfRdData),
    .doutOut(doutOut), .doutOe(doutOe), .resultReadyN(resultReadyN),
    .rfAddr(rfAddr), .rfWrData(rfWrData), .rfWrEn(rfWrEn)
  );

  assign rfRdData = mem[rfAddr];

  always @(posedge clk) begin
    if (rfWrEn) begin
      mem[rfAddr] <= rfWrData;
      wrCount++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  // host bit loop: drive edge sets DIN, sample edge reads DOUT
  task automatic shiftBits(input logic [31:0] v, input int n);
    capQ = '0;
    oeSeen = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      sclkIn = ~polSel;
      dinIn = v[i];
      #(HALF);
      capQ = {capQ[30:0], doutOut};
      if (doutOe) oeSeen = 1'b1;
      sclkIn = polSel;
      #(HALF);
    end
    dinIn = 1'b1;
  endtask

  task automatic testReset();
    checkEq("R10 ready pin idle after reset", resultReadyN, 1);
    checkEq("R6 oe low after reset", doutOe, 0);
    checkEq("R3 no write after reset", rfWrEn, 0);
  endtask

  task automatic testWrite16();
    int wc = wrCount;
    shiftBits(8'h02, 8);
    shiftBits(32'hBEEF, 16);
    checkEq("R6 oe low during write", oeSeen, 0);
    #40;
    checkEq("R3 one write pulse", wrCount, wc + 1);
    checkEq("R3 write data reg2", mem[2], 24'h00BEEF);
    shiftBits(8'h42, 8);
    checkEq("R6 oe low during command", oeSeen, 0);
    shiftBits(0, 16);
    checkEq("R2 16-bit readback", capQ[15:0], 16'hBEEF);
    checkEq("R6 oe high during read", oeSeen, 1);
  endtask

  task automatic testBurst();
    shiftBits({16'h0, 8'h04, 8'hA5}, 16);
    #40;
    checkEq("R4 command plus data in one burst", mem[4], 24'h0000A5);
    shiftBits(8'h44, 8);
    shiftBits(0, 8);
    checkEq("R2 8-bit readback", capQ[7:0], 8'hA5);
  endtask

  task automatic testOverlong();
    int wc = wrCount;
    shiftBits(8'h03, 8);
    shiftBits({24'h123456, 8'hFF}, 32);
    #40;
    checkEq("R5 single write for 32-bit burst", wrCount, wc + 1);
    checkEq("R5 24-bit data kept", mem[3], 24'h123456);
    shiftBits(8'h43, 8);
    shiftBits(0, 24);
    checkEq("R5 port back in command state", capQ[23:0], 24'h123456);
  endtask

  task automatic testNop();
    int wc = wrCount;
    shiftBits(8'hFF, 8);
    checkEq("R1 no-op drives nothing", oeSeen, 0);
    #40;
    checkEq("R1 no-op writes nothing", wrCount, wc);
    shiftBits(8'h45, 8);
    shiftBits(0, 24);
    checkEq("R1 command after no-op", capQ[23:0], mem[5]);
  endtask

  task automatic testPolarity();
    polSel = 1'b1;
    sclkIn = 1'b1;
    #100;
    shiftBits(8'h06, 8);
    shiftBits(32'h00C0DE, 24);
    #40;
    checkEq("R8 write with idle-high clock", mem[6], 24'h00C0DE);
    shiftBits(8'h46, 8);
    shiftBits(0, 24);
    checkEq("R8 read with idle-high clock", capQ[23:0], 24'h00C0DE);
    polSel = 1'b0;
    sclkIn = 1'b0;
    #100;
  endtask

  task automatic testReady();
    logic [23:0] dataVal = mem[1];
    newResult = 1'b1;
    #10;
    newResult = 1'b0;
    #10;
    checkEq("R10 pin asserted on new result", resultReadyN, 0);
    shiftBits(8'h40, 8);
    shiftBits(0, 8);
    checkEq("R10 status bit 7 set", capQ[7:0], {1'b1, mem[0][6:0]});
    checkEq("R10 status read keeps flag", resultReadyN, 0);
    shiftBits(8'h41, 8);
    shiftBits(0, 24);
    checkEq("R10 data register read", capQ[23:0], dataVal);
    #40;
    checkEq("R10 flag cleared by data read", resultReadyN, 1);
    shiftBits(8'h40, 8);
    shiftBits(0, 8);
    checkEq("R10 status bit 7 clear", capQ[7:0], {1'b0, mem[0][6:0]});
  endtask

  task automatic testStream();
    int wc;
    mem[1] = 24'h5A5A5A;
    shiftBits(8'h61, 8);
    shiftBits(32'hFF0700, 24);
    checkEq("R7 stream burst 1", capQ[23:0], 24'h5A5A5A);
    shiftBits(32'hFFFF30, 24);
    checkEq("R7 stream burst 2 no command needed", capQ[23:0], 24'h5A5A5A);
    wc = wrCount;
    shiftBits(8'h07, 8);
    checkEq("R7 stream left after exit byte", oeSeen, 0);
    shiftBits(32'h777777, 24);
    #40;
    checkEq("R7 command accepted after exit", wrCount, wc + 1);
    checkEq("R7 write after exit", mem[7], 24'h777777);
  endtask

  task automatic testChipSelect();
    int wc = wrCount;
    shiftBits(8'h02, 8);
    shiftBits(32'h15, 5);
    csN = 1'b1;
    #100;
    csN = 1'b0;
    #100;
    checkEq("R9 aborted write not issued", wrCount, wc);
    shiftBits(8'h42, 8);
    shiftBits(0, 16);
    checkEq("R9 framing restarts after deselect", capQ[15:0], 16'hBEEF);
    shiftBits(8'h61, 8);
    shiftBits(0, 24);
    csN = 1'b1;
    #100;
    checkEq("R9 oe dropped on deselect", doutOe, 0);
    csN = 1'b0;
    #100;
    shiftBits(8'h06, 8);
    shiftBits(32'h0A0B0C, 24);
    #40;
    checkEq("R9 streaming cleared by deselect", mem[6], 24'h0A0B0C);
  endtask

  initial begin
    #3_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 24'h010203 + 24'(i * 5);
    rstN = 1'b0;
    repeat (5) @(posedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    #100;
    testReset();
    testWrite16();
    testBurst();
    testOverlong();
    testNop();
    testPolarity();
    testReady();
    testStream();
    testChipSelect();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule